// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of signed 8-bit input vectors by a signed 8-bit weight matrix that stays resident in a square grid of N x N multiply-accumulate cells. Each cell holds two weights: an active weight that the running multiply uses, and a shadow weight that can be refilled at the same time. Shadow weights are filled one matrix row per cycle. Each new row enters at the top and pushes the rows already loaded one row down. A single swap strobe then copies every shadow weight into its active register on the same edge.

Input element r enters grid row r after r cycles of skew delay. Activations move one cell to the right per cycle and partial sums move one cell down per cycle, so each vector crosses the grid as a diagonal wavefront. The bottom edge produces one column sum per cycle. Delay lines re-align these sums, and an output register presents all N results of a vector together under one valid flag.

A vector can be accepted on every cycle. A small controller tracks whether any vector is still inside the grid. It has three states:
- **IDLE**: the grid is empty.
- **RUN**: a vector was accepted on the last edge.
- **DRAIN**: input has stopped, a countdown runs while the last wavefront leaves the grid, and the controller then returns to IDLE.

Transitions:
- IDLE goes to RUN on `in_valid`.
- RUN goes to DRAIN when `in_valid` is low, and the countdown is loaded with 2N-4.
- DRAIN goes back to RUN on `in_valid`.
- DRAIN goes to IDLE when the countdown is zero.

The swap strobe takes effect only in IDLE with no vector presented in the same cycle. N must be at least 2.

Top module: `sysmm_array`

## Requirements
- R1: For each accepted vector x, output element c equals the sum over r of x[r]·A[r][c] as a signed 32-bit value. A is the active weight matrix. Input element r sits at `in_vec[8r+7:8r]` and output element c at `out_vec[32c+31:32c]`, all two's complement.
- R2: `out_valid` is high for exactly one cycle per accepted vector, 2N-1 rising edges after the edge that accepted it, with results in acceptance order. It is low at all other times.
- R3: Vectors presented on consecutive cycles are all accepted and yield results on consecutive cycles.
- R4: Each edge with `wt_valid` high shifts the shadow matrix down one row and writes `wt_row` into row 0, with column c at `wt_row[8c+7:8c]`. After N loads, the first row loaded sits in row N-1. Loading never changes results until a swap.
- R5: An accepted swap copies all shadow weights into the active weights on one edge. Vectors accepted on later edges use the new matrix. Consecutive swaps are each accepted.
- R6: A swap is ignored when `in_valid` is high in the same cycle, or when any vector was accepted within the previous 2N-2 edges. Results then keep using the old weights.
- R7: When a swap and a weight load fall on the same edge, the swap copies the shadow contents from before that edge's shift.
- R8: After reset, `out_valid` and `out_vec` are zero and both weight sets are zero, so a vector sent before any swap yields an all-zero result.
- R9: Extreme operands are exact, e.g. all weights and inputs at -128 give 16384·N in every column, and mixed 127/-128 products keep their sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_valid | input | 1 | Shift `wt_row` into shadow row 0 |
| wt_row | input | 8·N | One row of signed weights, column c in byte c |
| wt_swap | input | 1 | Request copy of shadow to active weights |
| in_valid | input | 1 | `in_vec` holds a vector to accept |
| in_vec | input | 8·N | Signed input vector, element r in byte r |
| out_valid | output | 1 | `out_vec` holds an aligned result |
| out_vec | output | 32·N | Signed results, column c in word c |

## Verification
Every cycle, the assertions check three things:
- Each cell's partial sum stays within the bound set by its row depth.
- The active weights move only on an accepted swap, and the shadow weights move only on a load.
- The controller never grants a swap, and never reports IDLE, while a wavefront is still inside the grid.

Only the bench scenarios can show the rest:
- The arithmetic, including the -128 and 127 extremes.
- The exact 2N-1 edge latency and result order under back-to-back streaming.
- The row placement produced by the shift loading.
- Whether a swap at the boundary edges just before and just after the busy window is dropped or applied.
- The precedence when a swap and a load share an edge.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;
    localparam int DATA_W   = 8;
    localparam int ACC_W    = 32;
    localparam int PROD_MAX = 1 << (2 * DATA_W - 2);

    typedef logic signed [DATA_W-1:0]   data_t;
    typedef logic signed [2*DATA_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } flow_state_e;
endpackage

// File: rtl/sysmm_pe.sv
module sysmm_pe
    import sysmm_pkg::*;
#(
    parameter int ROW = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sh_en,
    input  logic  swap,
    input  data_t sh_in,
    output data_t sh_out,
    input  data_t x_in,
    output data_t x_out,
    input  acc_t  ps_in,
    output acc_t  ps_out
);
    localparam int BOUND = (ROW + 1) * PROD_MAX;

    data_t w_sh;
    data_t w_act;
    prod_t prod;

    assign prod   = x_in * w_act;
    assign sh_out = w_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_sh   <= '0;
            w_act  <= '0;
            x_out  <= '0;
            ps_out <= '0;
        end else begin
            if (sh_en) begin
                w_sh <= sh_in;
            end
            if (swap) begin
                w_act <= w_sh;
            end
            x_out  <= x_in;
            ps_out <= ps_in + acc_t'(prod);
        end
    end

    // R1: partial sum bounded by the number of rows above plus this one
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_out <= BOUND) && (ps_out >= -BOUND));

    // R4: shadow weight only moves on a load
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_en |=> $stable(w_sh));

    // R5: active weight only moves on an accepted swap
    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !swap |=> $stable(w_act));
endmodule

// File: rtl/sysmm_ctrl.sv
module sysmm_ctrl
    import sysmm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic wt_swap,
    output logic swap_go,
    output logic cap_en,
    output logic out_valid
);
    localparam int LAT    = 2 * N - 1;
    localparam int CW     = $clog2(LAT + 1);
    localparam int DRAINC = LAT - 3;

    flow_state_e state;
    flow_state_e state_nx;
    logic [CW-1:0] cnt;
    logic [LAT:0]  vpipe;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_valid) state_nx = ST_RUN;
            ST_RUN:   if (!in_valid) state_nx = ST_DRAIN;
            ST_DRAIN: begin
                if (in_valid) begin
                    state_nx = ST_RUN;
                end else if (cnt == '0) begin
                    state_nx = ST_IDLE;
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            vpipe <= '0;
        end else begin
            state <= state_nx;
            vpipe <= {vpipe[LAT-1:0], in_valid};
            if (state == ST_RUN && !in_valid) begin
                cnt <= CW'(DRAINC);
            end else if (state == ST_DRAIN && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        swap_go   = wt_swap && (state == ST_IDLE) && !in_valid;
        cap_en    = vpipe[LAT-1];
        out_valid = vpipe[LAT];
    end

    // R6: a granted swap never meets a wavefront inside the grid
    assert_swap_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        swap_go |-> ~|vpipe[LAT-2:0]);

    // R6: IDLE is only reported once the grid holds no vector
    assert_idle_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> ~|vpipe[LAT-2:0]);
endmodule

// File: rtl/sysmm_deskew.sv
module sysmm_deskew
    import sysmm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic [N*ACC_W-1:0] col_in,
    output logic [N*ACC_W-1:0] out_vec
);
    acc_t aligned [N];

    for (genvar c = 0; c < N; c++) begin : g_col
        localparam int D = N - 1 - c;
        if (D == 0) begin : g_direct
            assign aligned[c] = col_in[c*ACC_W +: ACC_W];
        end else begin : g_delay
            acc_t dly [D];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < D; i++) dly[i] <= '0;
                end else begin
                    dly[0] <= col_in[c*ACC_W +: ACC_W];
                    for (int i = 1; i < D; i++) dly[i] <= dly[i-1];
                end
            end
            assign aligned[c] = dly[D-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vec <= '0;
        end else if (cap_en) begin
            for (int c = 0; c < N; c++) out_vec[c*ACC_W +: ACC_W] <= aligned[c];
        end
    end
endmodule

// File: rtl/sysmm_array.sv
module sysmm_array
    import sysmm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wt_valid,
    input  logic [N*DATA_W-1:0] wt_row,
    input  logic                wt_swap,
    input  logic                in_valid,
    input  logic [N*DATA_W-1:0] in_vec,
    output logic                out_valid,
    output logic [N*ACC_W-1:0]  out_vec
);
    data_t x_h  [N][N+1];
    acc_t  ps_v [N+1][N];
    data_t sh_v [N][N];
    logic  swap_go;
    logic  cap_en;
    logic [N*ACC_W-1:0] bottom;

    sysmm_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .wt_swap   (wt_swap),
        .swap_go   (swap_go),
        .cap_en    (cap_en),
        .out_valid (out_valid)
    );

    for (genvar r = 0; r < N; r++) begin : g_skew
        data_t gated;
        assign gated = in_valid ? data_t'(in_vec[r*DATA_W +: DATA_W]) : '0;
        if (r == 0) begin : g_none
            assign x_h[r][0] = gated;
        end else begin : g_chain
            data_t sk [r];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < r; i++) sk[i] <= '0;
                end else begin
                    sk[0] <= gated;
                    for (int i = 1; i < r; i++) sk[i] <= sk[i-1];
                end
            end
            assign x_h[r][0] = sk[r-1];
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_top
        assign ps_v[0][c] = '0;
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_cell
            data_t sh_src;
            if (r == 0) begin : g_src_port
                assign sh_src = data_t'(wt_row[c*DATA_W +: DATA_W]);
            end else begin : g_src_above
                assign sh_src = sh_v[r-1][c];
            end
            sysmm_pe #(.ROW(r)) u_pe (
                .clk    (clk),
                .rst_n  (rst_n),
                .sh_en  (wt_valid),
                .swap   (swap_go),
                .sh_in  (sh_src),
                .sh_out (sh_v[r][c]),
                .x_in   (x_h[r][c]),
                .x_out  (x_h[r][c+1]),
                .ps_in  (ps_v[r][c]),
                .ps_out (ps_v[r+1][c])
            );
        end
    end

    for (genvar c = 0; c < N; c++) begin : g_bottom
        assign bottom[c*ACC_W +: ACC_W] = ps_v[N][c];
    end

    sysmm_deskew #(.N(N)) u_deskew (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .col_in  (bottom),
        .out_vec (out_vec)
    );
endmodule

// File: tb/sysmm_array_tb.sv
`timescale 1ns/1ps
module sysmm_array_tb;
    localparam int N   = 4;
    localparam int LAT = 2 * N - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              wt_valid = 1'b0;
    logic [N*8-1:0]    wt_row = '0;
    logic              wt_swap = 1'b0;
    logic              in_valid = 1'b0;
    logic [N*8-1:0]    in_vec = '0;
    logic              out_valid;
    logic [N*32-1:0]   out_vec;

    sysmm_array #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wt_valid(wt_valid), .wt_row(wt_row),
        .wt_swap(wt_swap), .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    int nchk = 0;
    int nfail = 0;
    string tag = "R8";
    int wm  [N][N];
    int sh  [N][N];
    int act [N][N];
    int cyc = 0;
    int last_acc = -1000;
    int due_q [$];
    logic [N*32-1:0] exp_q [$];

    function automatic logic [N*32-1:0] ref_mul(logic [N*8-1:0] v);
        logic [N*32-1:0] res;
        for (int c = 0; c < N; c++) begin
            int s = 0;
            for (int r = 0; r < N; r++) begin
                logic signed [7:0] xe;
                xe = v[r*8 +: 8];
                s += int'(xe) * act[r][c];
            end
            res[c*32 +: 32] = s;
        end
        return res;
    endfunction

    // behavioural reference, updated on every edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    sh[r][c] = 0;
                    act[r][c] = 0;
                end
            cyc = 0;
            last_acc = -1000;
            due_q.delete();
            exp_q.delete();
        end else begin
            bit swap_eff;
            cyc++;
            swap_eff = wt_swap && !in_valid && (cyc - last_acc > LAT - 1);
            if (in_valid) begin
                exp_q.push_back(ref_mul(in_vec));
                due_q.push_back(cyc + LAT);
                last_acc = cyc;
            end
            if (swap_eff)
                for (int r = 0; r < N; r++)
                    for (int c = 0; c < N; c++) act[r][c] = sh[r][c];
            if (wt_valid) begin
                for (int r = N - 1; r > 0; r--)
                    for (int c = 0; c < N; c++) sh[r][c] = sh[r-1][c];
                for (int c = 0; c < N; c++) begin
                    logic signed [7:0] we;
                    we = wt_row[c*8 +: 8];
                    sh[0][c] = int'(we);
                end
            end
        end
    end

    // compare against the reference on every clock
    always @(negedge clk) begin
        if (rst_n && cyc > 0) begin
            bit ev;
            ev = (due_q.size() > 0) && (due_q[0] == cyc);
            nchk++;
            if (out_valid !== ev) begin
                nfail++;
                $display("FAIL R2: out_valid got %b expected %b at cycle %0d", out_valid, ev, cyc);
            end
            if (ev) begin
                nchk++;
                if (out_vec !== exp_q[0]) begin
                    nfail++;
                    $display("FAIL %s: out_vec got %h expected %h", tag, out_vec, exp_q[0]);
                end
                void'(due_q.pop_front());
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic drive(bit wv, logic [N*8-1:0] row, bit sw, bit iv, logic [N*8-1:0] vec);
        @(negedge clk);
        wt_valid = wv; wt_row = row; wt_swap = sw; in_valid = iv; in_vec = vec;
    endtask

    task automatic idle(int n);
        repeat (n) drive(0, '0, 0, 0, '0);
    endtask

    function automatic logic [N*8-1:0] wrow(int r);
        logic [N*8-1:0] v;
        for (int c = 0; c < N; c++) v[c*8 +: 8] = 8'(wm[r][c]);
        return v;
    endfunction

    function automatic logic [N*8-1:0] mkvec(int seed);
        logic [N*8-1:0] v;
        for (int i = 0; i < N; i++) v[i*8 +: 8] = 8'(((seed * 37 + i * 53) % 256) - 128);
        return v;
    endfunction

    function automatic logic [N*8-1:0] fillvec(int val);
        logic [N*8-1:0] v;
        for (int i = 0; i < N; i++) v[i*8 +: 8] = 8'(val);
        return v;
    endfunction

    task automatic set_w(int mode);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                case (mode)
                    0: wm[r][c] = r * N + c - 7;
                    1: wm[r][c] = (r == c) ? 3 : -(r + 2 * c);
                    2: wm[r][c] = -128;
                    3: wm[r][c] = ((r + c) % 2 == 0) ? 127 : -128;
                    default: wm[r][c] = 11 * r - 5 * c + 1;
                endcase
    endtask

    // the first row sent ends up in the bottom row (R4)
    task automatic load_w(bit with_vec, int seed);
        for (int r = N - 1; r >= 0; r--) drive(1, wrow(r), 0, with_vec, with_vec ? mkvec(seed + r) : '0);
    endtask

    task automatic swap();
        drive(0, '0, 1, 0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        nchk++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            nfail++;
            $display("FAIL R8: reset outputs got %b/%h expected 0/0", out_valid, out_vec);
        end
        rst_n = 1'b1;
        idle(2);
        nchk++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            nfail++;
            $display("FAIL R8: post-reset outputs got %b/%h expected 0/0", out_valid, out_vec);
        end

        tag = "R8";  drive(0, '0, 0, 1, mkvec(5)); idle(LAT + 2);

        tag = "R4";  set_w(0); load_w(0, 0); drive(0, '0, 0, 1, mkvec(9)); idle(LAT + 2);
        tag = "R1";  swap();
        for (int i = 0; i < 4; i++) begin drive(0, '0, 0, 1, mkvec(i + 20)); idle(i); end
        idle(LAT + 2);
        tag = "R3";  for (int i = 0; i < 8; i++) drive(0, '0, 0, 1, mkvec(i + 40));
        idle(LAT + 2);

        tag = "R6";  set_w(1); load_w(1, 60);
        drive(0, '0, 1, 1, mkvec(70));
        swap();
        drive(0, '0, 0, 1, mkvec(71));
        idle(LAT - 2); swap();
        drive(0, '0, 0, 1, mkvec(72)); idle(LAT + 2);
        tag = "R5";  drive(0, '0, 0, 1, mkvec(73)); idle(LAT - 1); swap();
        drive(0, '0, 0, 1, mkvec(74)); drive(0, '0, 0, 1, mkvec(75)); idle(LAT + 2);

        tag = "R7";  set_w(4);
        for (int r = N - 1; r >= 1; r--) drive(1, wrow(r), 0, 0, '0);
        drive(1, wrow(0), 1, 0, '0);
        drive(0, '0, 0, 1, mkvec(80)); idle(LAT + 2);
        swap(); drive(0, '0, 0, 1, mkvec(81)); idle(LAT + 2);

        tag = "R9";  set_w(2); load_w(0, 0); swap();
        drive(0, '0, 0, 1, fillvec(-128)); drive(0, '0, 0, 1, fillvec(127)); idle(LAT + 2);
        set_w(3); load_w(0, 0); swap();
        drive(0, '0, 0, 1, fillvec(-128)); drive(0, '0, 0, 1, fillvec(127));
        drive(0, '0, 0, 1, mkvec(90)); idle(LAT + 2);

        tag = "R5";  set_w(0); load_w(0, 0); swap(); set_w(1); load_w(0, 0); swap(); swap();
        drive(0, '0, 0, 1, mkvec(95)); idle(LAT + 2);

        if (due_q.size() != 0) begin
            nfail++;
            $display("FAIL R2: pending results got %0d expected 0", due_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R2: watchdog got hang expected completion");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule